// File: doc/BRIEF.md
# Interrupt Request Flag Register with Pin Edge and Port Change Detection

This block holds three pending-interrupt flags in an 8-bit register and raises one interrupt request line when any enabled flag is pending. One flag follows an active-low external interrupt pin and is set on its falling edge. A second flag watches a 4-bit input port and is set whenever any bit of the port changes level. A third flag is set by a single-cycle overflow pulse from a timer that sits outside this block. Both asynchronous inputs (the pin and the port) go through two-flop synchronizers before any edge or change is detected.

Software reads the register through a combinational read port and clears flags by writing it. A write keeps every flag whose data bit is 1 and clears every flag whose data bit is 0, so a read-modify-write of the value just read clears exactly the serviced flags. A hardware set always beats a clear landing on the same flag in the same cycle. The enable mask and the interrupt vectoring live elsewhere; the block only takes three enable inputs and returns the masked OR.

Two small state machines carry the detection. The pin detector has the states `EX_WAIT` (after reset, waiting for a synchronized high), `EX_HIGH` and `EX_LOW`. Its transitions are `arm` (`EX_WAIT` to `EX_HIGH` on a high level), `fall` (`EX_HIGH` to `EX_LOW` on a low level, which emits the set pulse) and `rise` (`EX_LOW` to `EX_HIGH` on a high level). The port detector has `PC_WARM` (the reference copy is loaded while the synchronizer fills, with no flagging) and `PC_TRACK`. Its only transition is `settle` (`PC_WARM` to `PC_TRACK` after the warm-up count). In `PC_TRACK` the reference copy is reloaded every cycle and any difference emits a set pulse.

Top module: `irq_flag_reg`

## Requirements
- R1: The readable register holds the pin flag in bit 2, the port-change flag in bit 1 and the timer flag in bit 0. A 1 means pending, and all bits read 0 during and directly after reset.
- R2: Bits 7 to 3 always read 0, and writing 1s to them changes nothing.
- R3: A high-to-low transition of the external pin sets bit 2, readable after the third rising clock edge that follows the transition. A low-to-high transition or a held level sets nothing.
- R4: Any level change on one or more port bits sets bit 1, readable after the third rising edge that follows the change. While the new value is held, the flag is not set again after it has been cleared.
- R5: A timer overflow pulse high at a rising edge sets bit 0, readable right after that edge.
- R6: A write clears each of bits 2 to 0 whose write-data bit is 0 and leaves unchanged each whose write-data bit is 1. A write never sets a flag.
- R7: With no write, a set flag stays set indefinitely.
- R8: When a hardware set and a clearing write hit the same flag at the same edge, the flag ends set.
- R9: The request output equals the OR over bits 2 to 0 of flag AND enable input (enable bit i gates flag bit i) and follows the enables with no clock delay.
- R10: A port value that differs from zero at reset release is not flagged during the three-cycle warm-up. A pin held low through reset is not flagged until it has been seen high and then falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low synchronous reset |
| ext_irq_n_i | input | 1 | Asynchronous active-low external interrupt pin |
| port_i | input | 4 | Asynchronous input port watched for changes |
| tmr_ovf_i | input | 1 | Single-cycle timer overflow pulse, synchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data; a 0 in bits 2..0 clears that flag |
| en_i | input | 3 | Per-flag interrupt enables, bit i gates flag i |
| rd_data_o | output | 8 | Register read value |
| irq_o | output | 1 | Masked interrupt request |

## Verification
Pin and port results fall due after the third rising edge following the input change: two edges for the synchronizer and one for the flag register. The bench samples one nanosecond after the second edge, expecting no flag, and again after the third, expecting it. Timer flags and write effects are due after the single edge that captures them, and the request output is checked one nanosecond after the enables change, with no edge in between. The port check sweeps every one of the 256 ordered value pairs. The flag/enable check sweeps all 64 combinations, each compared with a mask-and-OR computed in the bench.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
    localparam int FLAG_N   = 3;
    localparam int TMR_BIT  = 0;
    localparam int CHG_BIT  = 1;
    localparam int EXT_BIT  = 2;

    typedef enum logic [1:0] {
        EX_WAIT = 2'd0,
        EX_HIGH = 2'd1,
        EX_LOW  = 2'd2
    } ext_state_t;

    typedef enum logic {
        PC_WARM  = 1'b0,
        PC_TRACK = 1'b1
    } chg_state_t;
endpackage

// File: rtl/irqf_sync.sv
module irqf_sync #(
    parameter int         W       = 1,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] stage_q;

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) stage_q[0] <= RST_VAL;
        else          stage_q[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk_i) begin
            if (!rst_n_i) stage_q[s] <= RST_VAL;
            else          stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irqf_fall_fsm.sv
module irqf_fall_fsm
    import irqf_pkg::*;
(
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic lvl_i,
    output logic fall_o
);
    ext_state_t state_q, state_d;

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) state_q <= EX_WAIT;
        else          state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        fall_o  = 1'b0;
        unique case (state_q)
            EX_WAIT: if (lvl_i) state_d = EX_HIGH;
            EX_HIGH: if (!lvl_i) begin
                         state_d = EX_LOW;
                         fall_o  = 1'b1;
                     end
            EX_LOW:  if (lvl_i) state_d = EX_HIGH;
            default: state_d = EX_WAIT;
        endcase
    end
endmodule

// File: rtl/irqf_chg_fsm.sv
module irqf_chg_fsm
    import irqf_pkg::*;
#(
    parameter int W        = 4,
    parameter int WARM_LEN = 3
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic [W-1:0] lvl_i,
    output logic         chg_o
);
    localparam int CW = $clog2(WARM_LEN + 1);
    localparam logic [CW-1:0] WARM_LAST = CW'(WARM_LEN - 1);

    chg_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [W-1:0]  ref_q;

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            state_q <= PC_WARM;
            cnt_q   <= '0;
            ref_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ref_q   <= lvl_i;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        chg_o   = 1'b0;
        unique case (state_q)
            PC_WARM: begin
                cnt_d = cnt_q + 1'b1;
                if (cnt_q == WARM_LAST) state_d = PC_TRACK;
            end
            PC_TRACK: chg_o = (lvl_i != ref_q);
            default:  state_d = PC_WARM;
        endcase
    end
endmodule

// File: rtl/irqf_flag_bank.sv
module irqf_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic [N-1:0] set_i,
    input  logic         wr_en_i,
    input  logic [N-1:0] keep_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] flag_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk_i) begin
            if (!rst_n_i)
                flag_q[i] <= 1'b0;
            else if (set_i[i])
                flag_q[i] <= 1'b1;
            else if (wr_en_i && !keep_i[i])
                flag_q[i] <= 1'b0;
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
    import irqf_pkg::*;
#(
    parameter int PORT_W      = 4,
    parameter int REG_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              ext_irq_n_i,
    input  logic [PORT_W-1:0] port_i,
    input  logic              tmr_ovf_i,
    input  logic              wr_en_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic [FLAG_N-1:0] en_i,
    output logic [REG_W-1:0]  rd_data_o,
    output logic              irq_o
);
    localparam int WARM_LEN = SYNC_STAGES + 1;

    logic              ext_lvl;
    logic [PORT_W-1:0] port_lvl;
    logic              ext_fall;
    logic              port_chg;
    logic [FLAG_N-1:0] set_vec;
    logic [FLAG_N-1:0] flags;
    logic              unused_wr_hi;

    irqf_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ext_sync (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .d_i     (ext_irq_n_i),
        .q_o     (ext_lvl)
    );

    irqf_sync #(.W(PORT_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_port_sync (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .d_i     (port_i),
        .q_o     (port_lvl)
    );

    irqf_fall_fsm u_ext_det (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .lvl_i   (ext_lvl),
        .fall_o  (ext_fall)
    );

    irqf_chg_fsm #(.W(PORT_W), .WARM_LEN(WARM_LEN)) u_port_det (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .lvl_i   (port_lvl),
        .chg_o   (port_chg)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[EXT_BIT] = ext_fall;
        set_vec[CHG_BIT] = port_chg;
        set_vec[TMR_BIT] = tmr_ovf_i;
    end

    irqf_flag_bank #(.N(FLAG_N)) u_flags (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .set_i   (set_vec),
        .wr_en_i (wr_en_i),
        .keep_i  (wr_data_i[FLAG_N-1:0]),
        .flag_o  (flags)
    );

    assign unused_wr_hi = &{1'b0, wr_data_i[REG_W-1:FLAG_N]};

    assign rd_data_o = {{(REG_W-FLAG_N){1'b0}}, flags};
    assign irq_o     = |(flags & en_i);
endmodule

// File: rtl/irqf_chk.sv
module irqf_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tmr_ovf,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       ext_fall,
    input logic       port_chg
);
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (|wr_data[7:3])) |=> (rd_data[7:3] == 5'd0));

    a_r5_tmr_sets: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> rd_data[0]);

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_ovf && wr_en && !wr_data[0]) |=> rd_data[0]);

    a_r6_clear_tmr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[0] && !tmr_ovf) |=> !rd_data[0]);

    a_r6_clear_chg: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[1] && !port_chg) |=> !rd_data[1]);

    a_r6_clear_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[2] && !ext_fall) |=> !rd_data[2]);

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((rd_data[2:0] & $past(rd_data[2:0])) == $past(rd_data[2:0])));

    a_r3_ext_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[2]) |-> $past(ext_fall));

    a_r4_chg_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[1]) |-> $past(port_chg));
endmodule

bind irq_flag_reg irqf_chk u_chk (
    .clk      (clk_i),
    .rst_n    (rst_n_i),
    .tmr_ovf  (tmr_ovf_i),
    .wr_en    (wr_en_i),
    .wr_data  (wr_data_i),
    .rd_data  (rd_data_o),
    .ext_fall (ext_fall),
    .port_chg (port_chg)
);

// File: tb/sim_irq_flag_reg.sv
`timescale 1ns/1ps
module sim_irq_flag_reg;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       ext_n;
    logic [3:0] port;
    logic       tmr;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [2:0] en;
    logic [7:0] rd;
    logic       irq;

    int n_cmp = 0;
    int n_mis = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    irq_flag_reg u0 (
        .clk_i       (clk),
        .rst_n_i     (rst_n),
        .ext_irq_n_i (ext_n),
        .port_i      (port),
        .tmr_ovf_i   (tmr),
        .wr_en_i     (wr_en),
        .wr_data_i   (wr_data),
        .en_i        (en),
        .rd_data_o   (rd),
        .irq_o       (irq)
    );

    task automatic tick(int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_mis++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        tick();
        wr_en   = 1'b0;
        wr_data = 8'h00;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
            $finish;
        end
    endtask

    task automatic set_all();
        ext_n = 1'b1;
        port  = 4'h3;
        tick(5);
        ext_n = 1'b0;
        port  = 4'hC;
        tick(4);
        tmr = 1'b1;
        tick();
        tmr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_mis++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; ext_n = 1'b0; port = 4'hA; tmr = 1'b0;
        wr_en = 1'b0; wr_data = 8'h00; en = 3'b111;
        tick(3);
        chk("R1 reset read", rd, 8'h00);
        chk("R1 reset irq", irq, 0);
        rst_n = 1'b1;
        tick(6);
        chk("R10 port warm-up not flagged", rd[1], 0);
        chk("R10 pin low at reset not flagged", rd[2], 0);

        // R3: rising edge sets nothing, falling edge sets after third edge
        ext_n = 1'b1;
        tick(5);
        chk("R3 rising edge", rd[2], 0);
        ext_n = 1'b0;
        tick(2);
        chk("R3 fall not yet due", rd[2], 0);
        tick();
        chk("R3 fall due", rd[2], 1);
        tick(6);
        chk("R7 ext flag held", rd[2], 1);
        wr(8'hFB);
        chk("R6 ext cleared", rd[2], 0);
        tick(6);
        chk("R3 held low no reflag", rd[2], 0);

        // R5 timer
        tmr = 1'b1;
        tick();
        tmr = 1'b0;
        chk("R5 timer set", rd, 8'h01);
        tick(7);
        chk("R7 timer held", rd[0], 1);
        wr(8'hFF);
        chk("R6 write 1 keeps", rd, 8'h01);
        wr(8'h00);
        chk("R6 write 0 clears", rd, 8'h00);
        wr(8'hFF);
        chk("R2 upper bits and no set by write", rd, 8'h00);

        // R8 set beats clear
        tmr = 1'b1; wr_en = 1'b1; wr_data = 8'h00;
        tick();
        tmr = 1'b0; wr_en = 1'b0;
        chk("R8 set wins", rd[0], 1);
        wr(8'h00);

        // R4 exhaustive port transitions
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                port = 4'(a);
                tick(4);
                wr(8'h00);
                chk("R4 settled", rd[1], 0);
                port = 4'(b);
                tick(2);
                chk("R4 not yet due", rd[1], 0);
                tick();
                chk("R4 change due", rd[1], (a != b) ? 1 : 0);
                tick(2);
                wr(8'hFD);
                tick(3);
                chk("R4 no reflag while held", rd[1], 0);
            end
        end

        // R9 exhaustive flag x enable
        for (int f = 0; f < 8; f++) begin
            set_all();
            chk("R1 all set", rd, 8'h07);
            wr(8'hF8 | 8'(f));
            chk("R6 selective clear", rd, 32'(f));
            for (int e = 0; e < 8; e++) begin
                en = 3'(e);
                #1;
                chk("R9 masked irq", irq, ((f & e) != 0) ? 1 : 0);
            end
            wr(8'h00);
        end

        finish_run();
    end
endmodule